// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits behind a two-wire serial memory's protocol engine and gathers the data bytes of a single-byte or multi-byte write into a page latch of 64 entries. The protocol engine gives it a transaction start with the 16-bit target address, one strobe per received data byte, the write-protect decision for that byte, and a STOP event with a flag that says whether the STOP fell in the slot directly after an acknowledge bit.

All bytes of one transaction stay in the row named by address bits 15..6. Only the low six bits advance, so a transaction that sends more bytes than remain in the row wraps back to the start of the same row and overwrites earlier latched bytes. A per-entry valid mask records which entries were received. The page is committed only by a correctly placed STOP. The block then scans the latch, drives the array write port once for each valid entry, and holds `busy` for a programmable number of clocks that stands for the cell programming time. When that time ends, the address counter output points to the byte after the last one accepted.

Top module: `page_write_buffer`

## Requirements
- R1: The row is taken from `txn_addr[15:6]` when `txn_start` is accepted. The first byte goes to offset `txn_addr[5:0]`, and each later accepted byte goes to the next offset. The row never changes within a transaction.
- R2: The offset advances modulo 64. A byte sent past offset 63 lands at offset 0 of the same row and replaces any byte latched there, so the last value written to an offset is the one committed.
- R3: A page is committed only when `stop_evt` comes with `stop_after_ack`=1. A STOP with `stop_after_ack`=0 discards the latch: the array port is not driven and `busy` stays low.
- R4: A byte strobed while `wr_protect`=1 is not latched and does not advance the offset. A transaction whose bytes were all protected starts no write cycle, even with a correctly placed STOP.
- R5: `busy` rises at the clock edge that samples a committing STOP. It stays high for exactly 64 + WRITE_CYCLES clock cycles. `arr_we` is asserted only while `busy` is high.
- R6: When `busy` falls, `addr_cnt` equals {row, offset after the last accepted byte}, with the offset wrapping within the row. `addr_cnt` changes at no other time.
- R7: Only latched offsets are written, each once. Every other byte of the row keeps its previous array value.
- R8: While `busy` is high, `txn_start`, byte strobes and STOP events have no effect. They start no later write and modify no array location.
- R9: After reset, `busy`=0, `arr_we`=0 and `addr_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Begin a write transaction (one-cycle pulse) |
| txn_addr | input | 16 | Start address of the transaction |
| byte_valid | input | 1 | Data byte strobe (one-cycle pulse) |
| byte_data | input | 8 | Received data byte |
| wr_protect | input | 1 | Write-protect decision for the strobed byte |
| stop_evt | input | 1 | STOP seen on the bus (one-cycle pulse) |
| stop_after_ack | input | 1 | STOP fell in the slot right after an ACK |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |
| addr_cnt | output | 16 | Address counter after the last completed write |

## Verification
A committing STOP that is sampled at edge k shows `busy` high at the following falling edge. The program scan then takes 64 cycles and the timer WRITE_CYCLES more, so the bench counts `busy` at every falling edge and expects exactly 64 + WRITE_CYCLES. Array writes are combinational from the scan state and are recorded at falling edges while the scan runs. `addr_cnt` is registered on the same edge at which `busy` falls, so the bench reads it one falling edge after it sees `busy` low. All inputs are driven at falling edges and held for one full cycle, so each strobe is sampled at exactly one rising edge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE,
    PW_FILL,
    PW_PROG,
    PW_WAIT
  } pw_state_e;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  mask;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  // one valid flag per entry, cleared as a group at each new transaction
  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask[g] <= 1'b0;
      else if (clr)                             mask[g] <= 1'b0;
      else if (wr_en && wr_idx == PAGE_W'(g))   mask[g] <= 1'b1;
    end
  end

  assign rd_data   = store[rd_idx];
  assign rd_valid  = mask[rd_idx];
  assign any_valid = |mask;
endmodule

// File: rtl/pwb_write_timer.sv
module pwb_write_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 6,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              wr_protect,
  input  logic              stop_evt,
  input  logic              stop_after_ack,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] addr_cnt
);
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] PAGE_LAST = '1;

  function automatic logic [PAGE_W-1:0] page_next(input logic [PAGE_W-1:0] off);
    return off + PAGE_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [ROW_W-1:0] r,
                                                   input logic [PAGE_W-1:0] off);
    return {r, off};
  endfunction

  pw_state_e         state, state_nx;
  logic [ROW_W-1:0]  row;
  logic [PAGE_W-1:0] ptr;
  logic [PAGE_W-1:0] scan_idx;

  // named internal events
  logic accept_start, latch_wr, commit_go, discard, scan_last, cycle_done;
  logic lat_valid, lat_any, tmr_done;
  logic [DATA_W-1:0] lat_data;

  always_comb begin
    accept_start = txn_start && (state == PW_IDLE || state == PW_FILL);
    latch_wr     = (state == PW_FILL) && !txn_start && !stop_evt
                   && byte_valid && !wr_protect;
    commit_go    = (state == PW_FILL) && !txn_start && stop_evt
                   && stop_after_ack && lat_any;
    discard      = (state == PW_FILL) && !txn_start && stop_evt && !commit_go;
    scan_last    = (state == PW_PROG) && (scan_idx == PAGE_LAST);
    cycle_done   = (state == PW_WAIT) && tmr_done;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      PW_IDLE: if (accept_start) state_nx = PW_FILL;
      PW_FILL: begin
        if (accept_start)   state_nx = PW_FILL;
        else if (commit_go) state_nx = PW_PROG;
        else if (discard)   state_nx = PW_IDLE;
      end
      PW_PROG: if (scan_last)  state_nx = PW_WAIT;
      PW_WAIT: if (cycle_done) state_nx = PW_IDLE;
      default: state_nx = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PW_IDLE;
      row      <= '0;
      ptr      <= '0;
      scan_idx <= '0;
      addr_cnt <= '0;
    end else begin
      state <= state_nx;
      if (accept_start) begin
        row <= txn_addr[ADDR_W-1:PAGE_W];
        ptr <= txn_addr[PAGE_W-1:0];
      end else if (latch_wr) begin
        ptr <= page_next(ptr);
      end
      if (commit_go)               scan_idx <= '0;
      else if (state == PW_PROG)   scan_idx <= page_next(scan_idx);
      if (cycle_done)              addr_cnt <= join_addr(row, ptr);
    end
  end

  pwb_page_latch #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept_start || discard),
    .wr_en     (latch_wr),
    .wr_idx    (ptr),
    .wr_data   (byte_data),
    .rd_idx    (scan_idx),
    .rd_data   (lat_data),
    .rd_valid  (lat_valid),
    .any_valid (lat_any)
  );

  pwb_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (scan_last),
    .done  (tmr_done)
  );

  assign busy      = (state == PW_PROG) || (state == PW_WAIT);
  assign arr_we    = (state == PW_PROG) && lat_valid;
  assign arr_addr  = join_addr(row, scan_idx);
  assign arr_wdata = lat_data;
endmodule

// File: rtl/pwb_checks.sv
module pwb_checks #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_evt,
  input logic              stop_after_ack,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [ADDR_W-1:0] addr_cnt,
  input logic              commit_go
);
  // R5: array port only active inside the write cycle
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R5: a commit event is followed by busy
  a_r5_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R3: busy only begins after a STOP in the slot after an ACK
  a_r3_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt && stop_after_ack));

  // R6: address counter moves only as busy ends
  a_r6_cnt_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_cnt) |-> ($past(busy) && !busy));

  // R1: consecutive array writes stay inside one row
  a_r1_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W])));
endmodule

bind page_write_buffer pwb_checks #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop_evt       (stop_evt),
  .stop_after_ack (stop_after_ack),
  .busy           (busy),
  .arr_we         (arr_we),
  .arr_addr       (arr_addr),
  .addr_cnt       (addr_cnt),
  .commit_go      (commit_go)
);

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int TB_W = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0;
  logic [15:0] txn_addr = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        wr_protect = 1'b0;
  logic        stop_evt = 1'b0;
  logic        stop_after_ack = 1'b0;
  logic        busy, arr_we;
  logic [15:0] arr_addr, addr_cnt;
  logic [7:0]  arr_wdata;

  int tests = 0;
  int fails = 0;
  int busy_cnt = 0;
  int wr_cnt = 0;
  logic finished = 1'b0;

  logic [7:0] got_arr [logic [15:0]];
  logic [7:0] exp_arr [logic [15:0]];
  logic [15:0] exp_cnt = '0;

  always #4 clk = ~clk;

  page_write_buffer #(.WRITE_CYCLES(TB_W)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .wr_protect(wr_protect),
    .stop_evt(stop_evt), .stop_after_ack(stop_after_ack), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .addr_cnt(addr_cnt)
  );

  // array model fed by the write port
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      got_arr[arr_addr] = arr_wdata;
      wr_cnt++;
    end
    if (rst_n && busy) busy_cnt++;
  end

  function automatic logic [5:0] next_off(input logic [5:0] o);
    return 6'((int'(o) + 1) % 64);
  endfunction

  function automatic logic [7:0] rd(input logic [15:0] a, input bit from_dut);
    if (from_dut) return got_arr.exists(a) ? got_arr[a] : 8'hFF;
    return exp_arr.exists(a) ? exp_arr[a] : 8'hFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_row(input string req, input logic [9:0] r);
    int bad = 0;
    logic [15:0] first = '0;
    for (int i = 0; i < 64; i++) begin
      if (rd({r, 6'(i)}, 1'b1) !== rd({r, 6'(i)}, 1'b0)) begin
        if (bad == 0) first = {r, 6'(i)};
        bad++;
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: row %0h addr %0h actual %0h expected %0h", req, r, first,
               rd(first, 1'b1), rd(first, 1'b0));
    end
  endtask

  task automatic pulse_start(input logic [15:0] a);
    @(negedge clk); txn_start = 1'b1; txn_addr = a;
    @(negedge clk); txn_start = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d, input logic wp);
    @(negedge clk); byte_valid = 1'b1; byte_data = d; wr_protect = wp;
    @(negedge clk); byte_valid = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic pulse_stop(input logic ok);
    @(negedge clk); stop_evt = 1'b1; stop_after_ack = ok;
    @(negedge clk); stop_evt = 1'b0; stop_after_ack = 1'b0;
  endtask

  // wp_mode: 0 none, 1 all protected, 2 random per byte
  task automatic run_txn(input logic [15:0] a, input int n, input int wp_mode,
                         input logic ok, input bit inject, input string req);
    logic [7:0]  lat [64];
    bit          msk [64];
    logic [5:0]  p = a[5:0];
    logic [9:0]  r = a[15:6];
    logic [15:0] a2 = {a[15:6] ^ 10'h155, 6'h00};
    int          nval = 0;
    bit          commit;
    for (int i = 0; i < 64; i++) msk[i] = 0;
    pulse_start(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      logic w = (wp_mode == 1) ? 1'b1 : (wp_mode == 2) ? 1'($urandom % 2) : 1'b0;
      pulse_byte(d, w);
      if (!w) begin lat[p] = d; msk[p] = 1; p = next_off(p); end
    end
    for (int i = 0; i < 64; i++) if (msk[i]) nval++;
    commit = ok && (nval != 0);
    busy_cnt = 0; wr_cnt = 0;
    pulse_stop(ok);
    if (inject) begin
      // R8: traffic during the write cycle must be ignored
      pulse_start(a2);
      for (int i = 0; i < 4; i++) pulse_byte(8'hA5 ^ 8'(i), 1'b0);
      pulse_stop(1'b1);
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    if (commit) begin
      for (int i = 0; i < 64; i++) if (msk[i]) exp_arr[{r, 6'(i)}] = lat[i];
      exp_cnt = {r, p};
    end
    check({req, " R5 busy length"}, busy_cnt, commit ? 64 + TB_W : 0);
    check({req, " R7 write count"}, wr_cnt, commit ? nval : 0);
    check_row({req, " R1 R2 R7 row content"}, r);
    check({req, " R6 addr_cnt"}, addr_cnt, exp_cnt);
    if (inject) begin
      check_row({req, " R8 injected row untouched"}, a2[15:6]);
      check({req, " R8 no second cycle"}, busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 arr_we", arr_we, 0);
    check("R9 addr_cnt", addr_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 busy after release", busy, 0);

    run_txn(16'h1234, 1, 0, 1'b1, 0, "single byte");
    run_txn(16'h2F3C, 70, 0, 1'b1, 0, "overfill wrap R2");
    run_txn(16'h0A7F, 1, 0, 1'b1, 0, "row end R6");
    run_txn(16'h4400, 5, 1, 1'b1, 0, "all protected R4");
    run_txn(16'h5510, 6, 0, 1'b0, 0, "bad stop slot R3");
    run_txn(16'h6620, 12, 2, 1'b1, 0, "mixed protect R4");
    run_txn(16'h7730, 3, 0, 1'b1, 1, "busy injection R8");
    for (int k = 0; k < 15; k++) begin
      int m = int'($urandom % 10);
      run_txn(16'($urandom), 1 + int'($urandom % 80), (m == 0) ? 1 : (m < 3) ? 2 : 0,
              1'(($urandom % 5) != 0), 0, "random");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule